// File: doc/BRIEF.md
# Timer Interrupt Vector Unit

This block gathers the event flags of a small timer with four sources and turns them into two CPU interrupt request lines. The sources are compare channel 0, compare channel 1, compare channel 2 and the counter overflow. Channel 0 drives a request line of its own, and that flag is dropped automatically when the CPU acknowledges the request. The other three sources share a second request line.

Software services the shared line through a vector register. A read of that register returns an even code for the most urgent pending, enabled source, and the same read clears that source's flag. Each code is twice a jump-table slot index, so a handler can add it straight to its program counter. A handler can also keep reading the vector until it gets 0, and service every pending event without leaving the handler.

Two further write addresses let software clear flags directly, or set them for test.

Top module: `tmr_irq_vec`

## Requirements
- R1: After a synchronous reset, every flag is clear, both request lines are low, `bus_rdata` is 0 and a vector read returns 0.
- R2: The vector codes are: 0 when nothing is pending, channel 1 = 2, channel 2 = 4, overflow = 10. Codes 6 and 8 are never returned. The code appears on `bus_rdata` in the cycle after the read strobe. `bus_rdata` is 0 in every other cycle.
- R3: When several shared sources are pending, the vector reports channel 1 before channel 2, and channel 2 before overflow.
- R4: A vector read clears only the flag of the source it reports. All other flags keep their value.
- R5: Repeated vector reads work through the pending sources in priority order and then return 0. A source that is set again after being cleared is ranked again on the next read.
- R6: A shared source whose enable bit is low is neither reported nor cleared by a vector read. Its flag stays pending and is reported once it is enabled.
- R7: Channel 0 never appears in the vector, and a vector read leaves the channel-0 flag unchanged.
- R8: `irq_ch0` is high exactly when the channel-0 flag and its enable are both set. `irq0_ack` clears that flag and leaves the shared flags unchanged.
- R9: When a set pulse meets a clear of the same flag in the same cycle (vector read, acknowledge or clear write), the flag ends up set.
- R10: A write to address 1 clears every flag whose data bit is 1. A write to address 2 sets every flag whose data bit is 1. The bit map is: bit 0 = channel 0, bit 1 = channel 1, bit 2 = channel 2, bit 3 = overflow.
- R11: `irq_shared` is high exactly when at least one enabled shared flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_set | input | 4 | One-cycle flag-set pulses from the timer core (bit 0 ch0, 1 ch1, 2 ch2, 3 overflow) |
| src_en | input | 4 | Interrupt enable bit for each source, same bit map |
| irq0_ack | input | 1 | CPU acknowledge for the channel-0 request |
| bus_sel | input | 1 | Bus select for this block |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | AW (2) | Register address: 0 vector, 1 clear, 2 set |
| bus_wdata | input | DW (16) | Write data |
| bus_rdata | output | DW (16) | Registered read data |
| irq_ch0 | output | 1 | Channel-0 interrupt request |
| irq_shared | output | 1 | Shared interrupt request for ch1, ch2 and overflow |

## Verification
A flag register left set, or cleared by mistake, shows at the ports within one cycle. A stray flag keeps a request line high after its source was serviced. A lost flag makes the next vector read return a lower-priority code or 0, one cycle after the strobe. A mismatch between the code and the flag that was cleared shows up on the following read: the reported source comes back a second time, or the next source in line is skipped. The bench therefore drains the queue after each scenario and compares every code returned against the order the requirements imply.

// File: rtl/tiv_pkg.sv
package tiv_pkg;
   // Source indices; the order matters for the bus bit map.
   localparam int unsigned NSRC    = 4;
   localparam int unsigned SRC_CH0 = 0;
   localparam int unsigned SRC_CH1 = 1;
   localparam int unsigned SRC_CH2 = 2;
   localparam int unsigned SRC_OVF = 3;

   localparam int unsigned CODE_W  = 4;

   typedef enum logic [CODE_W-1:0] {
      VEC_NONE = 4'd0,
      VEC_CH1  = 4'd2,
      VEC_CH2  = 4'd4,
      VEC_OVF  = 4'd10
   } vec_code_e;

   typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/tiv_flag_bank.sv
module tiv_flag_bank
   import tiv_pkg::*;
#(
   parameter int unsigned N = NSRC
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] flags_o
);
   initial begin
      if (N < 1) $error("tiv_flag_bank: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_flag
      always_ff @(posedge clk) begin
         if (rst)           flags_o[i] <= 1'b0;
         else if (set_i[i]) flags_o[i] <= 1'b1;   // set wins over clear
         else if (clr_i[i]) flags_o[i] <= 1'b0;
      end

      p_set_wins_r9 : assert property (@(posedge clk) disable iff (rst)
         set_i[i] |=> flags_o[i])
         else $error("R9: set pulse lost on flag %0d", i);
   end
endmodule

// File: rtl/tiv_vec_encode.sv
module tiv_vec_encode
   import tiv_pkg::*;
(
   input  logic [NSRC-1:0] pend_i,   // flags masked by enables
   output vec_code_e       code_o,
   output logic [NSRC-1:0] hit_o     // one-hot flag to clear
);
   always_comb begin
      code_o = VEC_NONE;
      hit_o  = '0;
      // Lowest priority first so that the higher ones overwrite it.
      if (pend_i[SRC_OVF]) begin
         code_o = VEC_OVF;
         hit_o  = src_vec_t'(1) << SRC_OVF;
      end
      if (pend_i[SRC_CH2]) begin
         code_o = VEC_CH2;
         hit_o  = src_vec_t'(1) << SRC_CH2;
      end
      if (pend_i[SRC_CH1]) begin
         code_o = VEC_CH1;
         hit_o  = src_vec_t'(1) << SRC_CH1;
      end
   end
endmodule

// File: rtl/tmr_irq_vec.sv
module tmr_irq_vec
   import tiv_pkg::*;
#(
   parameter int unsigned DW       = 16,
   parameter int unsigned AW       = 2,
   parameter int unsigned ADDR_VEC = 0,
   parameter int unsigned ADDR_CLR = 1,
   parameter int unsigned ADDR_SET = 2
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [3:0]    src_set,
   input  logic [3:0]    src_en,
   input  logic          irq0_ack,
   input  logic          bus_sel,
   input  logic          bus_rd,
   input  logic          bus_wr,
   input  logic [AW-1:0] bus_addr,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   output logic          irq_ch0,
   output logic          irq_shared
);
   localparam logic [AW-1:0] A_VEC = AW'(ADDR_VEC);
   localparam logic [AW-1:0] A_CLR = AW'(ADDR_CLR);
   localparam logic [AW-1:0] A_SET = AW'(ADDR_SET);
   localparam src_vec_t SHARED_MASK = src_vec_t'(~(1 << SRC_CH0));

   if (DW < 8) begin : g_bad_dw
      initial $error("tmr_irq_vec: DW must be at least 8");
   end
   if (ADDR_VEC == ADDR_CLR || ADDR_VEC == ADDR_SET || ADDR_CLR == ADDR_SET) begin : g_bad_addr
      initial $error("tmr_irq_vec: register addresses must differ");
   end
   if ((1 << AW) <= ADDR_SET || (1 << AW) <= ADDR_CLR || (1 << AW) <= ADDR_VEC) begin : g_bad_aw
      initial $error("tmr_irq_vec: AW too narrow for the address map");
   end

   logic      vec_rd;
   src_vec_t  clr_w, set_w, rd_clr, ack_clr;
   src_vec_t  set_all, clr_all;
   src_vec_t  flags, pend, hit;
   vec_code_e code;
   logic      unused_wbits;

   assign vec_rd  = bus_sel && bus_rd && (bus_addr == A_VEC);
   assign clr_w   = (bus_sel && bus_wr && bus_addr == A_CLR) ? bus_wdata[NSRC-1:0] : '0;
   assign set_w   = (bus_sel && bus_wr && bus_addr == A_SET) ? bus_wdata[NSRC-1:0] : '0;
   assign rd_clr  = vec_rd ? hit : '0;
   assign ack_clr = irq0_ack ? (src_vec_t'(1) << SRC_CH0) : '0;
   assign set_all = src_set | set_w;
   assign clr_all = clr_w | rd_clr | ack_clr;
   assign unused_wbits = ^bus_wdata[DW-1:NSRC];

   tiv_flag_bank #(.N(NSRC)) u_flags (
      .clk     (clk),
      .rst     (rst),
      .set_i   (set_all),
      .clr_i   (clr_all),
      .flags_o (flags)
   );

   assign pend = flags & src_en & SHARED_MASK;

   tiv_vec_encode u_enc (
      .pend_i (pend),
      .code_o (code),
      .hit_o  (hit)
   );

   // Code and clear come from the same flag snapshot in the same cycle.
   always_ff @(posedge clk) begin
      if (rst)         bus_rdata <= '0;
      else if (vec_rd) bus_rdata <= DW'(code);
      else             bus_rdata <= '0;
   end

   assign irq_ch0    = flags[SRC_CH0] & src_en[SRC_CH0];
   assign irq_shared = |pend;

   // Assertions
   p_code_legal_r2 : assert property (@(posedge clk) disable iff (rst)
      bus_rdata == DW'(0) || bus_rdata == DW'(2) || bus_rdata == DW'(4) || bus_rdata == DW'(10))
      else $error("R2: illegal vector code");

   p_hit_onehot_r3 : assert property (@(posedge clk) disable iff (rst)
      $onehot0(hit))
      else $error("R3: more than one source selected");

   for (genvar i = 1; i < NSRC; i++) begin : g_clr_chk
      p_clear_match_r4 : assert property (@(posedge clk) disable iff (rst)
         (vec_rd && hit[i] && !set_all[i]) |=> !flags[i])
         else $error("R4: reported flag %0d not cleared", i);
   end

   p_ch0_untouched_r7 : assert property (@(posedge clk) disable iff (rst)
      (vec_rd && flags[SRC_CH0] && !irq0_ack && !clr_w[SRC_CH0]) |=> flags[SRC_CH0])
      else $error("R7: vector read disturbed channel 0");

   p_ack_clear_r8 : assert property (@(posedge clk) disable iff (rst)
      (irq0_ack && !set_all[SRC_CH0]) |=> !flags[SRC_CH0])
      else $error("R8: acknowledge did not clear channel 0");
endmodule

// File: tb/tmr_irq_vec_bench.sv
module tmr_irq_vec_bench;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [3:0]    src_set = '0;
   logic [3:0]    src_en = '0;
   logic          irq0_ack = 1'b0;
   logic          bus_sel = 1'b0;
   logic          bus_rd = 1'b0;
   logic          bus_wr = 1'b0;
   logic [1:0]    bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          irq_ch0;
   logic          irq_shared;

   int n_chk  = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   tmr_irq_vec u_tmr_irq_vec (
      .clk(clk), .rst(rst), .src_set(src_set), .src_en(src_en),
      .irq0_ack(irq0_ack), .bus_sel(bus_sel), .bus_rd(bus_rd),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq_ch0(irq_ch0), .irq_shared(irq_shared)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic chk_eq(input string req, input int act, input int exp);
      chk(act == exp, req, act, exp);
   endtask

   task automatic pulse(input logic [3:0] m);
      @(negedge clk); src_set = m;
      @(negedge clk); src_set = '0;
   endtask

   task automatic rd_vec(output int code);
      @(negedge clk); bus_sel = 1; bus_rd = 1; bus_addr = 2'd0;
      @(negedge clk); bus_sel = 0; bus_rd = 0;
      code = int'(bus_rdata);
   endtask

   task automatic wr(input logic [1:0] a, input logic [3:0] d);
      @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = DW'(d);
      @(negedge clk); bus_sel = 0; bus_wr = 0; bus_wdata = '0;
   endtask

   task automatic do_reset();
      @(negedge clk); rst = 1; src_set = '0;
      @(negedge clk); @(negedge clk); rst = 0;
   endtask

   task automatic t_reset();
      int c;
      do_reset();
      src_en = 4'hF;
      chk_eq("R1 irq_ch0", int'(irq_ch0), 0);
      chk_eq("R1 irq_shared", int'(irq_shared), 0);
      chk_eq("R1 rdata", int'(bus_rdata), 0);
      rd_vec(c); chk_eq("R1 vector after reset", c, 0);
   endtask

   task automatic t_encode();
      int c;
      pulse(4'b0010); chk_eq("R11 irq_shared ch1", int'(irq_shared), 1);
      rd_vec(c); chk_eq("R2 code ch1", c, 2);
      @(negedge clk); chk_eq("R2 rdata idle", int'(bus_rdata), 0);
      pulse(4'b0100); rd_vec(c); chk_eq("R2 code ch2", c, 4);
      pulse(4'b1000); rd_vec(c); chk_eq("R2 code ovf", c, 10);
      chk_eq("R11 irq_shared drained", int'(irq_shared), 0);
   endtask

   task automatic t_priority_queue();
      int c;
      pulse(4'b1110);
      rd_vec(c); chk_eq("R3 first ch1", c, 2);
      rd_vec(c); chk_eq("R3 second ch2", c, 4);
      rd_vec(c); chk_eq("R5 third ovf", c, 10);
      rd_vec(c); chk_eq("R5 empty", c, 0);
   endtask

   task automatic t_clear_only();
      int c;
      pulse(4'b1100);
      rd_vec(c); chk_eq("R4 reports ch2", c, 4);
      chk_eq("R4 ovf still pending irq", int'(irq_shared), 1);
      rd_vec(c); chk_eq("R4 ovf kept", c, 10);
      rd_vec(c); chk_eq("R4 empty", c, 0);
   endtask

   task automatic t_reenter();
      int c;
      pulse(4'b0110);
      rd_vec(c); chk_eq("R5 ch1 first", c, 2);
      pulse(4'b0010);
      rd_vec(c); chk_eq("R5 ch1 re-ranked", c, 2);
      rd_vec(c); chk_eq("R5 then ch2", c, 4);
      rd_vec(c); chk_eq("R5 empty", c, 0);
   endtask

   task automatic t_disabled();
      int c;
      src_en = 4'b1101;
      pulse(4'b0110);
      chk_eq("R11 irq with ch2", int'(irq_shared), 1);
      rd_vec(c); chk_eq("R6 skips disabled ch1", c, 4);
      rd_vec(c); chk_eq("R6 nothing enabled", c, 0);
      chk_eq("R11 irq low with disabled flag", int'(irq_shared), 0);
      @(negedge clk); src_en = 4'hF;
      #1 chk_eq("R6 ch1 kept, irq", int'(irq_shared), 1);
      rd_vec(c); chk_eq("R6 ch1 reported", c, 2);
   endtask

   task automatic t_ch0();
      int c;
      src_en = 4'b1110;
      pulse(4'b0001);
      chk_eq("R8 irq_ch0 off while disabled", int'(irq_ch0), 0);
      @(negedge clk); src_en = 4'hF;
      #1 chk_eq("R8 irq_ch0 on", int'(irq_ch0), 1);
      chk_eq("R7 shared idle", int'(irq_shared), 0);
      rd_vec(c); chk_eq("R7 ch0 not in vector", c, 0);
      chk_eq("R7 ch0 kept", int'(irq_ch0), 1);
      pulse(4'b0100);
      @(negedge clk); irq0_ack = 1;
      @(negedge clk); irq0_ack = 0;
      chk_eq("R8 ack clears ch0", int'(irq_ch0), 0);
      rd_vec(c); chk_eq("R8 ack keeps ch2", c, 4);
   endtask

   task automatic t_collision();
      int c;
      pulse(4'b0010);
      @(negedge clk); bus_sel = 1; bus_rd = 1; bus_addr = 2'd0; src_set = 4'b0010;
      @(negedge clk); bus_sel = 0; bus_rd = 0; src_set = '0;
      chk_eq("R9 read during set", int'(bus_rdata), 2);
      rd_vec(c); chk_eq("R9 set survived read", c, 2);
      rd_vec(c); chk_eq("R9 empty", c, 0);
      pulse(4'b0001);
      @(negedge clk); irq0_ack = 1; src_set = 4'b0001;
      @(negedge clk); irq0_ack = 0; src_set = '0;
      chk_eq("R9 set survived ack", int'(irq_ch0), 1);
      @(negedge clk); irq0_ack = 1;
      @(negedge clk); irq0_ack = 0;
      chk_eq("R8 ch0 acked", int'(irq_ch0), 0);
   endtask

   task automatic t_writes();
      int c;
      wr(2'd2, 4'b1111);
      chk_eq("R10 set write ch0", int'(irq_ch0), 1);
      wr(2'd1, 4'b0011);
      chk_eq("R10 clear write ch0", int'(irq_ch0), 0);
      rd_vec(c); chk_eq("R10 ch1 cleared by write", c, 4);
      rd_vec(c); chk_eq("R10 ovf left", c, 10);
      pulse(4'b0010);
      @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = 2'd1; bus_wdata = DW'(4'b0010); src_set = 4'b0010;
      @(negedge clk); bus_sel = 0; bus_wr = 0; bus_wdata = '0; src_set = '0;
      rd_vec(c); chk_eq("R9 set beats clear write", c, 2);
      rd_vec(c); chk_eq("R10 empty", c, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      t_reset();
      t_encode();
      t_priority_queue();
      t_clear_only();
      t_reenter();
      t_disabled();
      t_ch0();
      t_collision();
      t_writes();
      t_reset();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule